// File: doc/BRIEF.md
# Virtual Interrupt List-Register Allocator

This block owns a small set of list-register slots through which interrupts are shown to one virtual CPU. A fill sequencer outside the block hands it queue requests one per cycle, each carrying an interrupt number, a source CPU number and a level/edge flag. The block either merges the request into a slot that already holds the same interrupt from the same source, or loads the lowest free slot. If neither is possible, the request is refused. It keeps a map from interrupt number to slot. It also keeps one active bit per interrupt, which locks out level interrupts until their end-of-interrupt arrives.

After a guest run, the block takes back two kinds of hardware status. End-of-interrupt reports release level interrupts. Empty-slot masks free slots and clear their map entries. The block raises a still-pending flag when work is left over. It also drives an underflow-interrupt enable that shows whether the last fill pass ran out of slots.

Top module: `lr_alloc`

## Requirements
- R1: After reset every slot is unused with pending and notify bits clear, the underflow enable is 0 and the still-pending flag is 0.
- R2: A request for an interrupt that has no matching slot and is not active is loaded into the lowest-numbered unused slot. That slot gets pending=1, the source, the interrupt ID and used=1, and `req_ok` is 1 in that cycle.
- R3: A request whose interrupt is mapped to a used slot with the same source field succeeds, sets that slot's pending bit and uses no new slot.
- R4: A request for a mapped interrupt with a different source field is treated as new and takes another slot.
- R5: For interrupt numbers 16 and above, the stored source field is 0 whatever source the request carries.
- R6: When no slot is free and the request can neither merge nor hit an active interrupt, `req_ok` is 0 and no slot changes.
- R7: A successful level request sets the slot's notify bit and the interrupt's active bit. While the active bit is set, a further request for that interrupt returns `req_ok`=1 and touches no slot.
- R8: `clear_pend` pulses in the same cycle as a successful edge request that loads or merges a slot. It stays 0 for level requests and for refused requests.
- R9: An end-of-interrupt report for a slot clears that slot's notify bit and the active bit of the interrupt it holds. If `eoi_line_pend` is 1, the still-pending flag is set.
- R10: `fill_end` sets the underflow enable if any request failed since `fill_start`; otherwise it clears both the underflow enable and the still-pending flag. `uf_evt` clears the underflow enable.
- R11: A sync frees each used slot whose `sync_empty` bit is 1, clearing its pending and notify bits and its map entry, so that a later request for that interrupt allocates afresh. If any `sync_empty` bit is 0, the still-pending flag is set.
- R12: A request presented in a sync cycle is stalled: `req_ok` is 0, no slot changes and it does not count as a failure for the fill pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Queue request strobe |
| req_irq | input | IW | Interrupt number of the request |
| req_src | input | SRC_W | Source CPU number of the request |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_ok | output | 1 | Request accepted this cycle |
| clear_pend | output | 1 | Distributor should drop the edge interrupt's pending state |
| fill_start | input | 1 | Start of a fill pass |
| fill_end | input | 1 | End of a fill pass |
| uf_evt | input | 1 | Underflow maintenance event |
| eoi_valid | input | 1 | End-of-interrupt report strobe |
| eoi_slot | input | SW | Slot that was EOIed |
| eoi_line_pend | input | 1 | Line still asserted for the EOIed interrupt |
| sync_valid | input | 1 | Empty-slot status strobe |
| sync_empty | input | NUM_LR | Per-slot empty status |
| lr_pend | output | NUM_LR | Per-slot pending bit |
| lr_eoi | output | NUM_LR | Per-slot notify-on-EOI bit |
| lr_used | output | NUM_LR | Per-slot occupied bit |
| lr_src | output | NUM_LR*SRC_W | Packed source fields, slot 0 in the low bits |
| lr_id | output | NUM_LR*IW | Packed interrupt IDs, slot 0 in the low bits |
| uie | output | 1 | Underflow-interrupt enable |
| still_pend | output | 1 | Work remains for this virtual CPU |

## Verification
An end-of-interrupt report and a queue request can both target the same level interrupt in one cycle. The request sees the active bit as it stood before the edge, so it succeeds without touching a slot. The report then clears the notify bit and the active bit, so the clear wins. The bench provokes this by queuing a level interrupt and then presenting a repeat request together with the EOI for its slot. It judges the result by checking that no second slot was taken, that the notify bit is 0 and that the still-pending flag is 1. It then frees the slot and checks that the next request allocates again, which shows the lockout has lifted.

// File: rtl/lr_alloc.sv
module lr_alloc #(
  parameter int NUM_LR    = 4,
  parameter int NUM_IRQ   = 64,
  parameter int SRC_W     = 3,
  parameter int PRIV_IRQS = 16,
  localparam int IW = $clog2(NUM_IRQ),
  localparam int SW = $clog2(NUM_LR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [IW-1:0]           req_irq,
  input  logic [SRC_W-1:0]        req_src,
  input  logic                    req_level,
  output logic                    req_ok,
  output logic                    clear_pend,
  input  logic                    fill_start,
  input  logic                    fill_end,
  input  logic                    uf_evt,
  input  logic                    eoi_valid,
  input  logic [SW-1:0]           eoi_slot,
  input  logic                    eoi_line_pend,
  input  logic                    sync_valid,
  input  logic [NUM_LR-1:0]       sync_empty,
  output logic [NUM_LR-1:0]       lr_pend,
  output logic [NUM_LR-1:0]       lr_eoi,
  output logic [NUM_LR-1:0]       lr_used,
  output logic [NUM_LR*SRC_W-1:0] lr_src,
  output logic [NUM_LR*IW-1:0]    lr_id,
  output logic                    uie,
  output logic                    still_pend
);

  logic [IW-1:0]    id_q   [NUM_LR];
  logic [SRC_W-1:0] src_q  [NUM_LR];
  logic [SW-1:0]    map_slot [NUM_IRQ];
  logic [NUM_IRQ-1:0] map_vld, act;
  logic [NUM_LR-1:0] pend_q, eoi_q, used_q;
  logic fail_acc, uie_q, spend_q;

  logic req_go, hit, is_act, free_ok, do_write, fail_now;
  logic [SW-1:0] hit_slot, free_slot, tgt;
  logic [SRC_W-1:0] src_eff;

  assign req_go   = req_valid & ~sync_valid;
  assign src_eff  = (req_irq >= IW'(PRIV_IRQS)) ? '0 : req_src;
  assign hit_slot = map_slot[req_irq];
  assign hit      = map_vld[req_irq] && used_q[hit_slot] && (src_q[hit_slot] == src_eff);
  assign is_act   = act[req_irq];

  always_comb begin
    free_ok   = 1'b0;
    free_slot = '0;
    for (int i = NUM_LR - 1; i >= 0; i--)
      if (!used_q[i]) begin
        free_ok   = 1'b1;
        free_slot = SW'(i);
      end
  end

  assign tgt        = hit ? hit_slot : free_slot;
  assign do_write   = req_go & ~is_act & (hit | free_ok);
  assign req_ok     = req_go & (is_act | hit | free_ok);
  assign fail_now   = req_go & ~req_ok;
  assign clear_pend = do_write & ~req_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LR; i++) begin
        id_q[i]  <= '0;
        src_q[i] <= '0;
      end
      for (int j = 0; j < NUM_IRQ; j++) map_slot[j] <= '0;
      map_vld  <= '0;
      act      <= '0;
      pend_q   <= '0;
      eoi_q    <= '0;
      used_q   <= '0;
      fail_acc <= 1'b0;
      uie_q    <= 1'b0;
      spend_q  <= 1'b0;
    end else begin
      if (do_write) begin
        pend_q[tgt] <= 1'b1;
        if (!hit) begin
          src_q[tgt]        <= src_eff;
          id_q[tgt]         <= req_irq;
          used_q[tgt]       <= 1'b1;
          eoi_q[tgt]        <= req_level;
          map_vld[req_irq]  <= 1'b1;
          map_slot[req_irq] <= tgt;
        end else if (req_level) begin
          eoi_q[tgt] <= 1'b1;
        end
        if (req_level) act[req_irq] <= 1'b1;
      end

      if (fill_start) fail_acc <= 1'b0;
      if (fail_now)   fail_acc <= 1'b1;
      if (fill_end) begin
        uie_q <= fail_acc | fail_now;
        if (!(fail_acc | fail_now)) spend_q <= 1'b0;
      end
      if (uf_evt) uie_q <= 1'b0;

      if (eoi_valid) begin
        act[id_q[eoi_slot]] <= 1'b0;
        eoi_q[eoi_slot]     <= 1'b0;
        if (eoi_line_pend) spend_q <= 1'b1;
      end

      if (sync_valid) begin
        for (int i = 0; i < NUM_LR; i++)
          if (sync_empty[i] && used_q[i]) begin
            used_q[i]         <= 1'b0;
            pend_q[i]         <= 1'b0;
            eoi_q[i]          <= 1'b0;
            map_vld[id_q[i]]  <= 1'b0;
          end
        if (~sync_empty != '0) spend_q <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_LR; g++) begin : g_pack
    assign lr_src[g*SRC_W +: SRC_W] = src_q[g];
    assign lr_id[g*IW +: IW]        = id_q[g];
  end

  assign lr_pend    = pend_q;
  assign lr_eoi     = eoi_q;
  assign lr_used    = used_q;
  assign uie        = uie_q;
  assign still_pend = spend_q;

endmodule

// File: rtl/lr_alloc_chk.sv
module lr_alloc_chk #(
  parameter int NUM_LR = 4,
  parameter int SW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_level,
  input logic              req_ok,
  input logic              clear_pend,
  input logic              sync_valid,
  input logic [NUM_LR-1:0] sync_empty,
  input logic              eoi_valid,
  input logic [SW-1:0]     eoi_slot,
  input logic              uf_evt,
  input logic [NUM_LR-1:0] lr_used,
  input logic [NUM_LR-1:0] lr_eoi,
  input logic              uie
);

  logic [NUM_LR-1:0] eoi_oh;
  assign eoi_oh = NUM_LR'(1) << eoi_slot;

  // R6
  refused_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sync_valid && !req_ok) |-> (&lr_used));

  // R12
  stall_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> !req_ok);

  // R8
  clear_pend_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pend |-> (req_ok && !req_level));

  // R9
  eoi_drops_notify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |=> ((lr_eoi & $past(eoi_oh)) == '0));

  // R11
  sync_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> ((lr_used & $past(sync_empty)) == '0));

  // R10
  uf_clears_uie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> !uie);

endmodule

bind lr_alloc lr_alloc_chk #(.NUM_LR(NUM_LR), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
  .req_ok(req_ok), .clear_pend(clear_pend), .sync_valid(sync_valid),
  .sync_empty(sync_empty), .eoi_valid(eoi_valid), .eoi_slot(eoi_slot),
  .uf_evt(uf_evt), .lr_used(lr_used), .lr_eoi(lr_eoi), .uie(uie)
);

// File: tb/lr_alloc_tb.sv
module lr_alloc_tb;
  localparam int CLK_P = 10;
  localparam int N = 4, IW = 6, SRCW = 3, SW = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_level = 0, fill_start = 0, fill_end = 0, uf_evt = 0;
  logic [IW-1:0] req_irq = '0;
  logic [SRCW-1:0] req_src = '0;
  logic eoi_valid = 0, eoi_line_pend = 0, sync_valid = 0;
  logic [SW-1:0] eoi_slot = '0;
  logic [N-1:0] sync_empty = '0;
  logic req_ok, clear_pend, uie, still_pend;
  logic [N-1:0] lr_pend, lr_eoi, lr_used;
  logic [N*SRCW-1:0] lr_src;
  logic [N*IW-1:0] lr_id;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  lr_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_irq(req_irq),
    .req_src(req_src), .req_level(req_level), .req_ok(req_ok), .clear_pend(clear_pend),
    .fill_start(fill_start), .fill_end(fill_end), .uf_evt(uf_evt),
    .eoi_valid(eoi_valid), .eoi_slot(eoi_slot), .eoi_line_pend(eoi_line_pend),
    .sync_valid(sync_valid), .sync_empty(sync_empty), .lr_pend(lr_pend),
    .lr_eoi(lr_eoi), .lr_used(lr_used), .lr_src(lr_src), .lr_id(lr_id),
    .uie(uie), .still_pend(still_pend)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic req(input int irq, input int src, input bit lvl, output bit ok, output bit cp);
    @(negedge clk);
    req_valid = 1; req_irq = IW'(irq); req_src = SRCW'(src); req_level = lvl;
    #(CLK_P/4); ok = req_ok; cp = clear_pend;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic eoi(input int slot, input bit lp);
    @(negedge clk); eoi_valid = 1; eoi_slot = SW'(slot); eoi_line_pend = lp;
    @(posedge clk); #1 eoi_valid = 0;
  endtask

  task automatic sync(input logic [N-1:0] m);
    @(negedge clk); sync_valid = 1; sync_empty = m;
    @(posedge clk); #1 sync_valid = 0;
  endtask

  task automatic pulse_fs(); @(negedge clk); fill_start = 1; @(posedge clk); #1 fill_start = 0; endtask
  task automatic pulse_fe(); @(negedge clk); fill_end = 1; @(posedge clk); #1 fill_end = 0; endtask
  task automatic pulse_uf(); @(negedge clk); uf_evt = 1; @(posedge clk); #1 uf_evt = 0; endtask

  function automatic int slot_id(int s);  return int'(lr_id[s*IW +: IW]); endfunction
  function automatic int slot_src(int s); return int'(lr_src[s*SRCW +: SRCW]); endfunction

  task automatic t_reset();
    do_reset(); @(negedge clk);
    chk("R1 used", lr_used, 0); chk("R1 pend", lr_pend, 0); chk("R1 eoi", lr_eoi, 0);
    chk("R1 uie", uie, 0); chk("R1 still_pend", still_pend, 0);
  endtask

  task automatic t_alloc();
    bit ok, cp;
    do_reset();
    req(40, 5, 0, ok, cp);
    chk("R2 ok", ok, 1); chk("R8 edge clear_pend", cp, 1);
    @(negedge clk);
    chk("R2 used", lr_used, 4'b0001); chk("R2 pend", lr_pend, 4'b0001);
    chk("R2 id", slot_id(0), 40); chk("R5 src forced zero", slot_src(0), 0);
    req(41, 0, 0, ok, cp);
    @(negedge clk);
    chk("R2 lowest free", lr_used, 4'b0011); chk("R2 id1", slot_id(1), 41);
  endtask

  task automatic t_merge();
    bit ok, cp;
    do_reset();
    req(3, 2, 0, ok, cp);
    @(negedge clk); chk("R5 sgi src kept", slot_src(0), 2);
    req(3, 2, 0, ok, cp);
    @(negedge clk);
    chk("R3 merge ok", ok, 1); chk("R3 no new slot", lr_used, 4'b0001);
    chk("R3 pend", lr_pend, 4'b0001);
    req(3, 4, 0, ok, cp);
    @(negedge clk);
    chk("R4 new slot", lr_used, 4'b0011); chk("R4 src", slot_src(1), 4);
    chk("R4 id", slot_id(1), 3);
  endtask

  task automatic t_full();
    bit ok, cp;
    do_reset();
    pulse_fs();
    for (int i = 0; i < N; i++) req(20 + i, 0, 0, ok, cp);
    req(24, 0, 0, ok, cp);
    chk("R6 refused", ok, 0); chk("R8 no clear on fail", cp, 0);
    @(negedge clk); chk("R6 slots unchanged", slot_id(3), 23);
    pulse_fe(); @(negedge clk); chk("R10 uie set", uie, 1);
    pulse_uf(); @(negedge clk); chk("R10 uf clears", uie, 0);
    pulse_fs(); req(24, 0, 0, ok, cp); pulse_fe();
    @(negedge clk); chk("R10 uie set again", uie, 1);
    pulse_fs(); pulse_fe();
    @(negedge clk); chk("R10 clean pass clears", uie, 0);
  endtask

  task automatic t_level();
    bit ok, cp;
    do_reset();
    req(50, 0, 1, ok, cp);
    chk("R8 level no clear", cp, 0);
    @(negedge clk); chk("R7 notify set", lr_eoi, 4'b0001);
    eoi(0, 0);
    @(negedge clk); chk("R9 notify cleared", lr_eoi, 0); chk("R9 no pend flag", still_pend, 0);
    req(51, 0, 1, ok, cp);
    @(negedge clk); chk("R2 level slot1", lr_used, 4'b0011);
    sync(4'b1111);
    @(negedge clk); chk("R11 all freed", lr_used, 0); chk("R11 all empty no flag", still_pend, 0);
    req(51, 0, 1, ok, cp);
    @(negedge clk); chk("R7 lockout ok", ok, 1); chk("R7 lockout no slot", lr_used, 0);
    req(50, 0, 1, ok, cp);
    @(negedge clk); chk("R9 released irq reallocates", lr_used, 4'b0001);
    eoi(1, 1);
    @(negedge clk); chk("R9 line pend flag", still_pend, 1);
    req(51, 0, 1, ok, cp);
    @(negedge clk); chk("R9 active cleared", lr_used, 4'b0011);
    pulse_fs(); pulse_fe();
    @(negedge clk); chk("R10 clean pass clears still_pend", still_pend, 0);
  endtask

  task automatic t_sync_map();
    bit ok, cp;
    do_reset();
    req(30, 0, 0, ok, cp); req(31, 0, 0, ok, cp);
    sync(4'b1101);
    @(negedge clk);
    chk("R11 partial free", lr_used, 4'b0010); chk("R11 non-empty flag", still_pend, 1);
    chk("R11 pend cleared", lr_pend, 4'b0010);
    req(31, 0, 0, ok, cp);
    @(negedge clk); chk("R3 kept map merges", lr_used, 4'b0010);
    req(30, 0, 0, ok, cp);
    @(negedge clk); chk("R11 map reset reallocates", lr_used, 4'b0011);
    chk("R11 id", slot_id(0), 30);
  endtask

  task automatic t_stall();
    bit ok;
    do_reset();
    pulse_fs();
    @(negedge clk);
    req_valid = 1; req_irq = 6'd33; req_src = '0; req_level = 0;
    sync_valid = 1; sync_empty = 4'b1111;
    #(CLK_P/4); ok = req_ok;
    @(posedge clk); #1 req_valid = 0; sync_valid = 0;
    chk("R12 stalled", ok, 0);
    @(negedge clk); chk("R12 no slot", lr_used, 0);
    pulse_fe();
    @(negedge clk); chk("R12 not a failure", uie, 0);
  endtask

  task automatic t_collide();
    bit ok;
    do_reset();
    begin bit cp; req(60, 0, 1, ok, cp); end
    @(negedge clk);
    req_valid = 1; req_irq = 6'd60; req_src = '0; req_level = 1;
    eoi_valid = 1; eoi_slot = '0; eoi_line_pend = 1;
    #(CLK_P/4); ok = req_ok;
    @(posedge clk); #1 req_valid = 0; eoi_valid = 0;
    chk("R7 collide ok", ok, 1);
    @(negedge clk);
    chk("R7 collide no new slot", lr_used, 4'b0001);
    chk("R9 collide notify clear", lr_eoi, 0);
    chk("R9 collide flag", still_pend, 1);
    sync(4'b1111);
    begin bit cp; req(60, 0, 1, ok, cp); end
    @(negedge clk); chk("R9 collide lockout lifted", lr_used, 4'b0001);
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_alloc();
    t_merge();
    t_full();
    t_level();
    t_sync_map();
    t_stall();
    t_collide();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule